// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts hardware events for profiling. Six counters each watch one line of a vector of single-cycle event pulses. Software picks the line for each counter with an 8-bit event code. Examples of such events are a level-1 data cache miss (code 0x03), a load instruction that executed with its condition passed (code 0x06), and a CPU clock cycle (code 0x11). In this block, code N means line N of the event input vector.

All access goes through a narrow write port and a read port. A counter-select register names one counter. Event-code writes and counter reads act only on the counter it names. Counting is gated by two things: a per-counter enable mask, which has separate set and clear addresses, and a global run bit in a control word. The same control word also carries a clear-all strobe. A typical sequence has five steps:
- select each counter and write its event code;
- set the enable bits;
- write 3 to the control word, which clears the counters and starts them;
- run the code being measured, then write 0 to stop;
- select each counter in turn and read it.

Top module: `pmu_top`

## Requirements
- R1: After reset, the following are all zero: every counter, every event code, the enable mask, the run bit and the select register.
- R2: A write to address 0 stores the low 3 bits of the data as the selected counter number. An event-code write (address 1) changes only the selected counter's code. When the selection is 6 or 7, an event-code write changes nothing, and reads of address 1 and address 5 return 0. Reading address 0 returns the selection.
- R3: An event-code write keeps only the low 8 data bits. Reading address 1 returns the selected counter's code.
- R4: A write to address 2 sets enable bit x for every data bit x (0 to 5) that is 1. Bits written as 0 and data bits above 5 leave the mask unchanged. Reading address 2 returns the mask in bits 5:0.
- R5: A write to address 3 clears enable bit x for every data bit x that is 1, and leaves the others unchanged. A disabled counter holds its value while running.
- R6: A write to the control word (address 4) works as follows. Data bit 1 set clears all six counters at that clock edge. Data bit 0 becomes the run bit, which starts (1) or stops (0) all counting. Writing 3 clears and starts in one operation. Reading address 4 returns the run bit in bit 0.
- R7: At each clock edge, counter x increases by exactly one if three things hold in the cycle before that edge: enable bit x is 1, the run bit is 1, and event line number (code x) is high. A code that names no event line (32 or more here) never counts.
- R8: When a clear and an increment fall on the same edge, the clear wins and the counter reads 0 afterwards.
- R9: Counters are CNT_W bits wide and wrap from all ones to zero.
- R10: Reading address 5 returns the selected counter's current value, zero-extended. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Register address of the combinational read |
| rd_data | output | DATA_W | Read data for rd_addr |
| ev_in | input | NUM_EV | Single-cycle event pulses, line N matches code N |

## Verification
A register write takes effect at the rising edge that samples it. A read at any address reflects that write at once, through combinational logic, before the next edge. An event pulse presented in a cycle is counted at the closing edge of that cycle. The clear strobe and the new run bit act at the edge of the control write itself, so the first event that can count is the one in the cycle after that write.

The bench drives every input just after a falling edge and lets exactly one rising edge pass per step. It updates its own counter model for that edge, using the enable and run state from before the write, and then applies the write. It samples rd_data 1 ns after the falling edge that follows.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int REG_ADDR_W   = 3;
  localparam int CODE_W       = 8;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_SEL   = 3'd0,
    REG_EVT   = 3'd1,
    REG_ENSET = 3'd2,
    REG_ENCLR = 3'd3,
    REG_CTRL  = 3'd4,
    REG_COUNT = 3'd5
  } reg_addr_e;

  // Set-only update of an enable mask held in an 8-bit field.
  function automatic logic [CODE_W-1:0] mask_set(input logic [CODE_W-1:0] cur,
                                                 input logic [CODE_W-1:0] ones);
    return cur | ones;
  endfunction

  // Clear-only update of an enable mask held in an 8-bit field.
  function automatic logic [CODE_W-1:0] mask_clr(input logic [CODE_W-1:0] cur,
                                                 input logic [CODE_W-1:0] ones);
    return cur & ~ones;
  endfunction

endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int SEL_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0]     cfg_data,
  output logic [SEL_W-1:0]      sel,
  output logic [NUM_CNT-1:0]    en_mask,
  output logic                  run,
  output logic                  clr_pulse,
  output logic [NUM_CNT-1:0]    evt_we
);

  logic wr_sel, wr_evt, wr_enset, wr_enclr, wr_ctrl;
  logic [CODE_W-1:0] mask_wide;
  logic [CODE_W-1:0] mask_next;

  assign wr_sel   = wr_en && (wr_addr == REG_SEL);
  assign wr_evt   = wr_en && (wr_addr == REG_EVT);
  assign wr_enset = wr_en && (wr_addr == REG_ENSET);
  assign wr_enclr = wr_en && (wr_addr == REG_ENCLR);
  assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);

  assign clr_pulse = wr_ctrl && cfg_data[CTRL_CLR_BIT];

  assign mask_wide = CODE_W'(en_mask);

  always_comb begin
    mask_next = mask_wide;
    if (wr_enset) begin
      mask_next = mask_set(mask_wide, cfg_data);
    end else if (wr_enclr) begin
      mask_next = mask_clr(mask_wide, cfg_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= '0;
      en_mask <= '0;
      run     <= 1'b0;
    end else begin
      if (wr_sel) begin
        sel <= cfg_data[SEL_W-1:0];
      end
      en_mask <= mask_next[NUM_CNT-1:0];
      if (wr_ctrl) begin
        run <= cfg_data[CTRL_RUN_BIT];
      end
    end
  end

  // A selection outside 0..NUM_CNT-1 matches no write enable.
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_we
    assign evt_we[g] = wr_evt && (sel == SEL_W'(g));
  end

  logic unused_mask_hi;
  assign unused_mask_hi = ^mask_next[CODE_W-1:NUM_CNT];

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EV = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [NUM_EV-1:0] ev_in,
  input  logic              count_en,
  input  logic              clr,
  output logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  count,
  output logic              inc
);

  // Line picked by an event code; a code past the last line never matches.
  function automatic logic event_hit(input logic [NUM_EV-1:0] ev,
                                     input logic [CODE_W-1:0] c);
    logic h;
    h = 1'b0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (c == CODE_W'(i)) begin
        h = ev[i];
      end
    end
    return h;
  endfunction

  // Next count: clear wins over a step, steps wrap at CNT_W bits.
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                            input logic              step,
                                            input logic              zap);
    if (zap) begin
      return '0;
    end
    return cur + CNT_W'(step);
  endfunction

  assign inc = count_en && event_hit(ev_in, code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= '0;
      count <= '0;
    end else begin
      if (cfg_we) begin
        code <= cfg_code;
      end
      count <= bump(count, inc, clr);
    end
  end

endmodule

// File: rtl/pmu_rdmux.sv
module pmu_rdmux
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 3
) (
  input  logic [REG_ADDR_W-1:0] rd_addr,
  input  logic [SEL_W-1:0]      sel,
  input  logic [CODE_W-1:0]     code_arr  [NUM_CNT],
  input  logic [CNT_W-1:0]      count_arr [NUM_CNT],
  input  logic [NUM_CNT-1:0]    en_mask,
  input  logic                  run,
  output logic [DATA_W-1:0]     rd_data
);

  logic [CODE_W-1:0] pick_code;
  logic [CNT_W-1:0]  pick_count;

  always_comb begin
    pick_code  = '0;
    pick_count = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel == SEL_W'(i)) begin
        pick_code  = code_arr[i];
        pick_count = count_arr[i];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_SEL:   rd_data = DATA_W'(sel);
      REG_EVT:   rd_data = DATA_W'(pick_code);
      REG_ENSET: rd_data = DATA_W'(en_mask);
      REG_ENCLR: rd_data = DATA_W'(en_mask);
      REG_CTRL:  rd_data = DATA_W'(run);
      REG_COUNT: rd_data = DATA_W'(pick_count);
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int NUM_EV  = 32,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_EV-1:0] ev_in
);

  localparam int SEL_W = $clog2(NUM_CNT + 1);

  logic [SEL_W-1:0]         sel;
  logic [NUM_CNT-1:0]       en_mask;
  logic                     run;
  logic                     clr_pulse;
  logic [NUM_CNT-1:0]       evt_we;
  logic [NUM_CNT-1:0]       inc_vec;
  logic [CODE_W-1:0]        code_arr  [NUM_CNT];
  logic [CNT_W-1:0]         count_arr [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  pmu_ctrl #(
    .NUM_CNT(NUM_CNT),
    .SEL_W  (SEL_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cfg_data (wr_data[CODE_W-1:0]),
    .sel      (sel),
    .en_mask  (en_mask),
    .run      (run),
    .clr_pulse(clr_pulse),
    .evt_we   (evt_we)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    pmu_counter #(
      .NUM_EV(NUM_EV),
      .CNT_W (CNT_W)
    ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (evt_we[g]),
      .cfg_code(wr_data[CODE_W-1:0]),
      .ev_in   (ev_in),
      .count_en(en_mask[g] && run),
      .clr     (clr_pulse),
      .code    (code_arr[g]),
      .count   (count_arr[g]),
      .inc     (inc_vec[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = count_arr[g];
  end

  pmu_rdmux #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_rdmux (
    .rd_addr  (rd_addr),
    .sel      (sel),
    .code_arr (code_arr),
    .count_arr(count_arr),
    .en_mask  (en_mask),
    .run      (run),
    .rd_data  (rd_data)
  );

  logic unused_wr_hi;
  assign unused_wr_hi = ^{wr_data[DATA_W-1:CODE_W], inc_vec, cnt_flat};

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [2:0]               wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [2:0]               rd_addr,
  input logic [DATA_W-1:0]        rd_data,
  input logic [SEL_W-1:0]         sel,
  input logic [NUM_CNT-1:0]       en_mask,
  input logic                     run,
  input logic                     clr_pulse,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

  logic unused_chk;
  assign unused_chk = ^wr_data;

  // R6: clear strobe leaves every counter at zero
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_flat == '0));

  // R6: control write loads the run bit
  p_run_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4) |=> (run == $past(wr_data[0])));

  // R6: stopped counters hold their values
  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_pulse) |=> $stable(cnt_flat));

  // R4: enable-set turns on every written one
  p_enset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2) |=>
      ((en_mask & $past(wr_data[NUM_CNT-1:0])) == $past(wr_data[NUM_CNT-1:0])));

  // R4: enable-set never turns a bit off
  p_enset_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2) |=> ((en_mask & $past(en_mask)) == $past(en_mask)));

  // R5: enable-clear turns off every written one
  p_enclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> ((en_mask & $past(wr_data[NUM_CNT-1:0])) == '0));

  // R2: counter read with an out-of-range selection returns zero
  p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd5 && sel >= SEL_W'(NUM_CNT)) |-> (rd_data == '0));

  // R7: a counter moves by at most one per edge, and only while running
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_step
    p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_pulse |=> ((cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W])) ||
                      (cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) + 1'b1)));
    // R5: a disabled counter holds
    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_mask[g] && !clr_pulse) |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
  end

endmodule

bind pmu_top pmu_checker #(
  .NUM_CNT(NUM_CNT),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .sel      (sel),
  .en_mask  (en_mask),
  .run      (run),
  .clr_pulse(clr_pulse),
  .cnt_flat (cnt_flat)
);

// File: tb/pmu_top_test.sv
`timescale 1ns/1ps
module pmu_top_test;

  localparam int NC = 6;
  localparam int NE = 32;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] ev_in = '0;

  int n_tot = 0;
  int n_bad = 0;

  int m_cnt  [NC];
  int m_code [NC];
  int m_en   = 0;
  int m_run  = 0;
  int m_sel  = 0;

  always #4 clk = ~clk;

  pmu_top #(.NUM_CNT(NC), .NUM_EV(NE), .CNT_W(CW), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in)
  );

  // One rising edge with the given inputs; model follows the same edge.
  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic [31:0] ev);
    wr_en = we; wr_addr = a; wr_data = d; ev_in = ev;
    @(posedge clk);
    for (int x = 0; x < NC; x++) begin
      if (m_run != 0 && m_en[x] != 0 && m_code[x] < NE && ev[m_code[x]])
        m_cnt[x] = (m_cnt[x] + 1) % (1 << CW);
    end
    if (we) begin
      case (a)
        3'd0: m_sel = int'(d[2:0]);
        3'd1: if (m_sel < NC) m_code[m_sel] = int'(d[7:0]);
        3'd2: m_en = m_en | int'(d[5:0]);
        3'd3: m_en = m_en & ~int'(d[5:0]);
        3'd4: begin
          m_run = int'(d[0]);
          if (d[1]) for (int x = 0; x < NC; x++) m_cnt[x] = 0;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; ev_in = '0;
  endtask

  task automatic chk(input logic [2:0] a, input int exp, input string tag);
    rd_addr = a;
    #1;
    n_tot++;
    if (rd_data !== 32'(exp)) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, 32'(exp));
    end
  endtask

  task automatic chk_counter(input int x, input string tag);
    cyc(1'b1, 3'd0, 32'(x), 32'h0);
    chk(3'd5, m_cnt[x], tag);
  endtask

  task automatic chk_all(input string tag);
    for (int x = 0; x < NC; x++) chk_counter(x, tag);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E3779B1) ^ (32'(i) << 5);
  endfunction

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    for (int x = 0; x < NC; x++) begin m_cnt[x] = 0; m_code[x] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(3'd0, 0, "R1 select");
    chk(3'd2, 0, "R1 enable");
    chk(3'd4, 0, "R1 run");
    for (int x = 0; x < NC; x++) begin
      cyc(1'b1, 3'd0, 32'(x), 32'h0);
      chk(3'd1, 0, "R1 code");
      chk(3'd5, 0, "R1 count");
    end

    // R3: only low 8 bits kept; R2: each write lands on the selected counter only
    for (int x = 0; x < NC; x++) begin
      cyc(1'b1, 3'd0, 32'(x), 32'h0);
      cyc(1'b1, 3'd1, 32'h0000_A300 + 32'(x + 1), 32'h0);
    end
    for (int x = 0; x < NC; x++) begin
      cyc(1'b1, 3'd0, 32'(x), 32'h0);
      chk(3'd1, x + 1, "R3 code low byte");
    end

    // R2: out-of-range selection
    cyc(1'b1, 3'd0, 32'h6, 32'h0);
    chk(3'd0, 6, "R2 select readback");
    cyc(1'b1, 3'd1, 32'h9, 32'h0);
    chk(3'd1, 0, "R2 code read out of range");
    chk(3'd5, 0, "R2 count read out of range");
    cyc(1'b1, 3'd0, 32'hF, 32'h0);
    chk(3'd0, 7, "R2 select low 3 bits");
    for (int x = 0; x < NC; x++) begin
      cyc(1'b1, 3'd0, 32'(x), 32'h0);
      chk(3'd1, m_code[x], "R2 codes untouched");
    end

    // R4: set-only enables
    cyc(1'b1, 3'd2, 32'hFFFF_FFD5, 32'h0);
    chk(3'd2, 32'h15, "R4 set ignores high bits");
    cyc(1'b1, 3'd2, 32'h0, 32'h0);
    chk(3'd2, 32'h15, "R4 zeros leave mask");
    cyc(1'b1, 3'd2, 32'h2A, 32'h0);
    chk(3'd2, 32'h3F, "R4 set remaining");

    // R5: clear-only enables
    cyc(1'b1, 3'd3, 32'h05, 32'h0);
    chk(3'd2, 32'h3A, "R5 clear bits");
    cyc(1'b1, 3'd3, 32'h0, 32'h0);
    chk(3'd2, 32'h3A, "R5 zeros leave mask");
    cyc(1'b1, 3'd2, 32'h05, 32'h0);
    chk(3'd2, 32'h3F, "R5 re-set");

    // R6 / R7: clear+start, count a pattern, stop
    cyc(1'b1, 3'd4, 32'h3, 32'h0);
    chk(3'd4, 1, "R6 run after 3");
    for (int i = 0; i < 60; i++) cyc(1'b0, 3'd0, 32'h0, pat(i));
    cyc(1'b1, 3'd4, 32'h0, 32'h0);
    chk(3'd4, 0, "R6 run after 0");
    chk_all("R7 pattern count");

    // R6: stopped counters ignore events
    for (int i = 0; i < 20; i++) cyc(1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF);
    chk_all("R6 stopped hold");

    // R5: disabled counter holds while others run
    cyc(1'b1, 3'd3, 32'h04, 32'h0);
    cyc(1'b1, 3'd4, 32'h1, 32'h0);
    for (int i = 0; i < 30; i++) cyc(1'b0, 3'd0, 32'h0, pat(i + 100));
    chk_all("R5 disabled hold");

    // R7: code naming no line never counts
    cyc(1'b1, 3'd0, 32'h0, 32'h0);
    cyc(1'b1, 3'd1, 32'h40, 32'h0);
    for (int i = 0; i < 10; i++) cyc(1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF);
    chk_counter(0, "R7 unmatched code");

    // R8: clear beats a same-edge increment
    cyc(1'b1, 3'd4, 32'h3, 32'hFFFF_FFFF);
    chk_all("R8 clear priority");
    cyc(1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF);
    chk_all("R8 counts after clear");

    // R9: wrap at CNT_W bits (300 mod 256 = 44)
    cyc(1'b1, 3'd2, 32'h3F, 32'h0);
    cyc(1'b1, 3'd0, 32'h0, 32'h0);
    cyc(1'b1, 3'd1, 32'h1, 32'h0);
    cyc(1'b1, 3'd4, 32'h3, 32'h0);
    for (int i = 0; i < 300; i++) cyc(1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF);
    cyc(1'b1, 3'd4, 32'h0, 32'h0);
    cyc(1'b1, 3'd0, 32'h1, 32'h0);
    chk(3'd5, 44, "R9 wrap literal");
    chk_all("R9 wrap all");

    // R10: current value read and unused addresses
    cyc(1'b1, 3'd0, 32'h3, 32'h0);
    chk(3'd5, m_cnt[3], "R10 selected value");
    chk(3'd6, 0, "R10 addr 6");
    chk(3'd7, 0, "R10 addr 7");

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule